// File: doc/BRIEF.md
# Serial Flash Custom Command Sequencer

This block lets a host send any short instruction to a serial flash device over a single-line SPI link. The host gives an opcode, a total frame length of 1 to 9 bytes, and two 32-bit words that hold up to eight payload bytes. The block shifts the opcode out on the data-out pin and then the payload. Each byte that the device returns during the payload is written back over the payload byte that was sent in that slot, so the host reads the response from the same two words. When the work is done the block pulses a single-cycle completion flag.

Two optional steps can run before the instruction. A status-poll step sends the read-status command (0x05) again and again until the device reports that it is no longer busy. A write-enable step sends 0x06 in a frame of its own. The two spare IO lines are held at levels that the host picks for the whole operation. In chained mode, chip select stays low after the first frame. The host then sends further payload chunks, and the frame closes only when a chunk is marked as the last one.

Top module: `flash_cmd_engine`

## Requirements
- R1: On an accepted `start`, the frame sends the opcode and then `total_len`-1 payload bytes, most significant bit first, under one chip-select low period. Payload byte k is bits [8k+7:8k] of {`wdata_hi`,`wdata_lo`}, and bytes go out in rising order of k.
- R2: A `total_len` of 0 acts as 1 (opcode only). A value above 9 acts as 9. A `cont_len` of 0 acts as 1, and a value above 8 acts as 8.
- R3: After completion, payload byte k of {`rdata_hi`,`rdata_lo`} holds the byte received in the slot where byte k was sent. Bytes beyond the length keep the value loaded from the write words.
- R4: With `wren_first` set, the frame {0x06} is sent alone before the instruction. Every chip-select high period between frames lasts at least `GAP_CYC` clock cycles.
- R5: With `wait_idle` set, frames {0x05, 0x00} are sent first and repeated while bit 0 of the second received byte is 1. `dev_status` holds the last status byte received.
- R6: `spi_io2` and `spi_io3` take `io2_level` and `io3_level` from the accepted `start` and stay unchanged while chip select is low.
- R7: With `long_mode` set, chip select stays low after the first frame and `ongoing` is 1. Each accepted `cont` sends `cont_len` payload bytes with no opcode and writes the received bytes back the same way as in R3. A `cont` with `cont_final` set closes the frame and clears `ongoing`.
- R8: `ready` is a one-cycle pulse at the end of each instruction or chunk, and `busy` is 0 while it is high. For a closed frame, `ready` comes after the deselect gap.
- R9: A `start` is ignored while `busy` is high or a chained frame is open. A `cont` is ignored unless a chained frame is open and `busy` is low.
- R10: `spi_sck` is low whenever `spi_csn` is high (clock idles low). Data is driven before the rising edge and sampled from `spi_miso` on it.
- R11: After reset, `spi_csn`=1, `spi_sck`=0, `ready`=0, `busy`=0, `ongoing`=0, `dev_status`=0 and the read words are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Request a new instruction |
| opcode | input | 8 | Instruction opcode |
| total_len | input | 4 | Frame length in bytes, opcode included |
| wdata_lo | input | 32 | Payload bytes 0..3 |
| wdata_hi | input | 32 | Payload bytes 4..7 |
| wren_first | input | 1 | Send write-enable frame first |
| wait_idle | input | 1 | Poll status until idle first |
| io2_level | input | 1 | Level for IO2 |
| io3_level | input | 1 | Level for IO3 |
| long_mode | input | 1 | Keep frame open after the instruction |
| cont | input | 1 | Send another chunk in an open frame |
| cont_len | input | 4 | Chunk length in payload bytes |
| cont_final | input | 1 | Close frame after this chunk |
| rdata_lo | output | 32 | Data bytes 0..3 (response written back) |
| rdata_hi | output | 32 | Data bytes 4..7 (response written back) |
| dev_status | output | 8 | Last status byte read |
| ready | output | 1 | Completion pulse |
| busy | output | 1 | Operation in progress |
| ongoing | output | 1 | Chained frame open |
| spi_sck | output | 1 | Serial clock |
| spi_csn | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| spi_io2 | output | 1 | Static IO2 level |
| spi_io3 | output | 1 | Static IO3 level |

## Verification
The assertions assume that `start` and `cont` are sampled only on clock edges. They also assume that the host asks for a chained frame only through `long_mode`, so `ongoing` with `busy` low always means the frame is open. Levels on `spi_miso` are taken as arbitrary and are never checked. The stimulus drives every request as a one-clock pulse on the falling edge. It never uses 0x05 as a custom opcode, so the device model tells poll frames apart from instruction frames. That model answers on serial-clock edges: it changes its output after each falling edge and captures on each rising edge, which matches the sampling convention of R10.

// File: rtl/fce_pkg.sv
package fce_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAUNCH,
    ST_POLL,
    ST_WREN,
    ST_MAIN,
    ST_HOLD,
    ST_DESEL
  } fce_state_e;

  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_RDSR = 8'h05;

  // total frame length, opcode included: 1..9
  function automatic logic [3:0] clamp_total(input logic [3:0] n);
    if (n == 4'd0) return 4'd1;
    if (n > 4'd9)  return 4'd9;
    return n;
  endfunction

  // chunk length in payload bytes: 1..8
  function automatic logic [3:0] clamp_chunk(input logic [3:0] n);
    if (n == 4'd0) return 4'd1;
    if (n > 4'd8)  return 4'd8;
    return n;
  endfunction

  function automatic logic [7:0] pick_byte(input logic [63:0] w, input logic [2:0] idx);
    return w[{idx, 3'b000} +: 8];
  endfunction

endpackage

// File: rtl/fce_bit_shifter.sv
module fce_bit_shifter #(
  parameter int unsigned HALF_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       go,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int unsigned DIVW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
  localparam logic [DIVW-1:0] DIV_LAST = DIVW'(HALF_CYC - 1);

  logic            act;
  logic [DIVW-1:0] div;
  logic [2:0]      bitc;
  logic [7:0]      sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act  <= 1'b0;
      div  <= '0;
      bitc <= '0;
      sh   <= '0;
      rx   <= '0;
      sck  <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go && !act) begin
        act  <= 1'b1;
        sh   <= tx;
        div  <= '0;
        bitc <= '0;
        sck  <= 1'b0;
      end else if (act) begin
        if (div == DIV_LAST) begin
          div <= '0;
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitc == 3'd7) begin
              act  <= 1'b0;
              done <= 1'b1;
            end else begin
              bitc <= bitc + 3'd1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end else begin
          div <= div + 1'b1;
        end
      end
    end
  end

  assign mosi = sh[7];

endmodule

// File: rtl/fce_data_regs.sv
module fce_data_regs #(
  parameter int unsigned NBYTES = 8,
  localparam int unsigned IW = $clog2(NBYTES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [NBYTES*8-1:0]   ld_data,
  input  logic                  wr,
  input  logic [IW-1:0]         wr_idx,
  input  logic [7:0]            wr_byte,
  output logic [NBYTES*8-1:0]   q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= ld_data;
    end else if (wr) begin
      q[{wr_idx, 3'b000} +: 8] <= wr_byte;
    end
  end
endmodule

// File: rtl/fce_gap_timer.sv
module fce_gap_timer #(
  parameter int unsigned GAP_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  output logic fire
);
  localparam int unsigned CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(GAP_CYC - 1);

  logic          run;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run  <= 1'b0;
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (kick) begin
        run <= 1'b1;
        cnt <= '0;
      end else if (run) begin
        if (cnt == CNT_LAST) begin
          run  <= 1'b0;
          fire <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/flash_cmd_engine.sv
module flash_cmd_engine
  import fce_pkg::*;
#(
  parameter int unsigned HALF_CYC = 2,
  parameter int unsigned GAP_CYC  = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  opcode,
  input  logic [3:0]  total_len,
  input  logic [31:0] wdata_lo,
  input  logic [31:0] wdata_hi,
  input  logic        wren_first,
  input  logic        wait_idle,
  input  logic        io2_level,
  input  logic        io3_level,
  input  logic        long_mode,
  input  logic        cont,
  input  logic [3:0]  cont_len,
  input  logic        cont_final,
  output logic [31:0] rdata_lo,
  output logic [31:0] rdata_hi,
  output logic [7:0]  dev_status,
  output logic        ready,
  output logic        busy,
  output logic        ongoing,
  output logic        spi_sck,
  output logic        spi_csn,
  output logic        spi_mosi,
  input  logic        spi_miso,
  output logic        spi_io2,
  output logic        spi_io3
);
  fce_state_e st;
  logic [7:0] op_q, txb_q, sh_rx;
  logic [3:0] len_q, seg_len, bidx;
  logic       dofs, pend_poll, pend_wren, final_q, fin_q;
  logic       go_q, kick_q, sh_done, gap_fire;
  logic [63:0] dq;

  // named internal events
  logic       start_ok, cont_ok, seg_end, dr_wr;
  logic [3:0] nxt_idx;
  logic [2:0] wr_sel, nxt_sel;

  assign start_ok = (st == ST_IDLE) && start;
  assign cont_ok  = (st == ST_HOLD) && cont;
  assign nxt_idx  = bidx + 4'd1;
  assign seg_end  = (nxt_idx == seg_len);
  assign wr_sel   = bidx[2:0] - {2'b00, dofs};
  assign nxt_sel  = nxt_idx[2:0] - {2'b00, dofs};
  assign dr_wr    = (st == ST_MAIN) && sh_done && (bidx >= {3'b000, dofs});

  fce_bit_shifter #(.HALF_CYC(HALF_CYC)) u_shift (
    .clk(clk), .rst_n(rst_n), .go(go_q), .tx(txb_q), .miso(spi_miso),
    .sck(spi_sck), .mosi(spi_mosi), .done(sh_done), .rx(sh_rx)
  );

  fce_data_regs #(.NBYTES(8)) u_dregs (
    .clk(clk), .rst_n(rst_n), .load(start_ok | cont_ok),
    .ld_data({wdata_hi, wdata_lo}), .wr(dr_wr), .wr_idx(wr_sel),
    .wr_byte(sh_rx), .q(dq)
  );

  fce_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .kick(kick_q), .fire(gap_fire)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      op_q       <= '0;
      txb_q      <= '0;
      len_q      <= 4'd1;
      seg_len    <= 4'd1;
      bidx       <= '0;
      dofs       <= 1'b1;
      pend_poll  <= 1'b0;
      pend_wren  <= 1'b0;
      final_q    <= 1'b1;
      fin_q      <= 1'b0;
      go_q       <= 1'b0;
      kick_q     <= 1'b0;
      spi_csn    <= 1'b1;
      ready      <= 1'b0;
      ongoing    <= 1'b0;
      dev_status <= '0;
      spi_io2    <= 1'b1;
      spi_io3    <= 1'b1;
    end else begin
      go_q   <= 1'b0;
      kick_q <= 1'b0;
      ready  <= 1'b0;
      case (st)
        ST_IDLE: if (start) begin
          op_q      <= opcode;
          len_q     <= clamp_total(total_len);
          pend_poll <= wait_idle;
          pend_wren <= wren_first;
          final_q   <= !long_mode;
          ongoing   <= long_mode;
          spi_io2   <= io2_level;
          spi_io3   <= io3_level;
          st        <= ST_LAUNCH;
        end
        ST_LAUNCH: begin
          spi_csn <= 1'b0;
          go_q    <= 1'b1;
          bidx    <= '0;
          if (pend_poll) begin
            st <= ST_POLL; txb_q <= OP_RDSR; seg_len <= 4'd2;
          end else if (pend_wren) begin
            st <= ST_WREN; txb_q <= OP_WREN; seg_len <= 4'd1;
          end else begin
            st <= ST_MAIN; txb_q <= op_q; seg_len <= len_q; dofs <= 1'b1;
          end
        end
        ST_POLL, ST_WREN, ST_MAIN: if (sh_done) begin
          if (!seg_end) begin
            bidx  <= nxt_idx;
            go_q  <= 1'b1;
            txb_q <= (st == ST_MAIN) ? pick_byte(dq, nxt_sel) : 8'h00;
          end else if (st == ST_MAIN && !final_q) begin
            st    <= ST_HOLD;
            ready <= 1'b1;
          end else begin
            spi_csn <= 1'b1;
            kick_q  <= 1'b1;
            st      <= ST_DESEL;
            fin_q   <= (st == ST_MAIN);
            if (st == ST_POLL) begin
              dev_status <= sh_rx;
              pend_poll  <= sh_rx[0];
            end
            if (st == ST_WREN) pend_wren <= 1'b0;
          end
        end
        ST_HOLD: if (cont) begin
          seg_len <= clamp_chunk(cont_len);
          dofs    <= 1'b0;
          bidx    <= '0;
          final_q <= cont_final;
          go_q    <= 1'b1;
          txb_q   <= wdata_lo[7:0];
          st      <= ST_MAIN;
        end
        ST_DESEL: if (gap_fire) begin
          if (fin_q) begin
            st      <= ST_IDLE;
            ready   <= 1'b1;
            ongoing <= 1'b0;
          end else begin
            st <= ST_LAUNCH;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (st != ST_IDLE) && (st != ST_HOLD);
  assign rdata_lo = dq[31:0];
  assign rdata_hi = dq[63:32];

endmodule

// File: rtl/flash_cmd_engine_chk.sv
module flash_cmd_engine_chk #(
  parameter int unsigned GAP_CYC = 4
) (
  input logic clk,
  input logic rst_n,
  input logic csn,
  input logic sck,
  input logic io2,
  input logic io3,
  input logic ready,
  input logic busy,
  input logic ongoing
);
  localparam int unsigned CW = $clog2(GAP_CYC + 1) + 1;
  localparam logic [CW-1:0] GAP_MIN = CW'(GAP_CYC);

  logic [CW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) hi_cnt <= GAP_MIN;
    else if (csn) begin
      if (hi_cnt < GAP_MIN) hi_cnt <= hi_cnt + 1'b1;
    end else hi_cnt <= '0;
  end

  // R4: deselect gap before each new frame
  a_r4_gap_min: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(csn) |-> hi_cnt >= GAP_MIN);

  // R6: spare IO levels steady inside a frame
  a_r6_io_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!csn && !$past(csn)) |-> ($stable(io2) && $stable(io3)));

  // R7: open chained frame keeps chip select low
  a_r7_hold_cs: assert property (@(posedge clk) disable iff (!rst_n)
    (ongoing && !busy) |-> !csn);

  // R8: completion is a single-cycle pulse
  a_r8_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> !ready);

  // R8: not busy at completion
  a_r8_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> !busy);

  // R10: clock idles low outside a frame
  a_r10_sck_idle: assert property (@(posedge clk) disable iff (!rst_n)
    csn |-> !sck);

endmodule

bind flash_cmd_engine flash_cmd_engine_chk #(.GAP_CYC(GAP_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .csn(spi_csn), .sck(spi_sck), .io2(spi_io2),
  .io3(spi_io3), .ready(ready), .busy(busy), .ongoing(ongoing)
);

// File: tb/test_flash_cmd_engine.sv
module test_flash_cmd_engine;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, wren_first = 1'b0, wait_idle = 1'b0;
  logic io2_level = 1'b0, io3_level = 1'b0, long_mode = 1'b0;
  logic cont = 1'b0, cont_final = 1'b0;
  logic [7:0]  opcode = '0;
  logic [3:0]  total_len = '0, cont_len = '0;
  logic [31:0] wdata_lo = '0, wdata_hi = '0;
  logic [31:0] rdata_lo, rdata_hi;
  logic [7:0]  dev_status;
  logic ready, busy, ongoing, sck, csn, mosi, io2, io3;
  logic miso = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_cmd_engine #(.HALF_CYC(2), .GAP_CYC(GAP)) i_flash_cmd_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .total_len(total_len),
    .wdata_lo(wdata_lo), .wdata_hi(wdata_hi), .wren_first(wren_first),
    .wait_idle(wait_idle), .io2_level(io2_level), .io3_level(io3_level),
    .long_mode(long_mode), .cont(cont), .cont_len(cont_len), .cont_final(cont_final),
    .rdata_lo(rdata_lo), .rdata_hi(rdata_hi), .dev_status(dev_status),
    .ready(ready), .busy(busy), .ongoing(ongoing), .spi_sck(sck), .spi_csn(csn),
    .spi_mosi(mosi), .spi_miso(miso), .spi_io2(io2), .spi_io3(io3)
  );

  int n_chk = 0, n_bad = 0;
  bit mon_en = 1'b0, finished = 1'b0;
  int exp_q[$];
  logic [7:0] resp_base = 8'h10;
  int polls_left = 0;
  int fpos = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bsel(input logic [63:0] w, input int j);
    return w[j*8 +: 8];
  endfunction

  // device model: serial flash answering on the bus
  int bitn = 0, fidx = 0;
  logic [7:0] sh_in = '0, dev_out = '0, first_byte = '0;

  always @(negedge csn) if (mon_en) begin
    bitn = 0; fidx = 0; first_byte = '0;
    dev_out = resp_base; miso = dev_out[7];
  end

  always @(posedge sck) if (mon_en && !csn) begin
    sh_in = {sh_in[6:0], mosi};
    bitn++;
    if (bitn % 8 == 0) begin
      if (fidx == 0) first_byte = sh_in;
      fidx++;
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected byte", 64'(sh_in), 64'hffff);
      else begin
        int e;
        e = exp_q.pop_front();
        chk(e == int'(sh_in), "R1 serial byte (MSB first, R10)", 64'(sh_in), 64'(e));
      end
    end
  end

  always @(negedge sck) if (mon_en && !csn) begin
    if (bitn % 8 == 0) begin
      if (first_byte == 8'h05 && fidx == 1) begin
        if (polls_left > 0) begin dev_out = 8'h03; polls_left--; end
        else dev_out = 8'h02;
      end else dev_out = resp_base + 8'(fidx);
    end else dev_out = {dev_out[6:0], 1'b0};
    miso = dev_out[7];
  end

  always @(posedge csn) if (mon_en) begin
    int e;
    e = (exp_q.size() == 0) ? 999 : exp_q.pop_front();
    chk(e == -1 && bitn % 8 == 0, "R1 frame end", 64'(bitn), 64'(e));
  end

  // gap and idle-clock monitors
  int hi_run = 1000, min_gap = 1000, sck_bad = 0;
  always @(negedge clk) if (mon_en) begin
    if (csn) begin
      hi_run++;
      if (sck) sck_bad++;
    end else if (hi_run > 0) begin
      if (hi_run < min_gap) min_gap = hi_run;
      hi_run = 0;
    end
  end

  task automatic wait_ready();
    @(negedge clk);
    while (!ready) @(negedge clk);
    chk(!busy, "R8 busy low at ready", 64'(busy), 64'd0);
    @(negedge clk);
    chk(!ready, "R8 ready single cycle", 64'(ready), 64'd0);
  endtask

  task automatic issue(input logic [7:0] op, input int len_in, input logic [31:0] lo,
                       input logic [31:0] hi, input bit we, input bit wip, input int npoll,
                       input bit l2, input bit l3, input bit lng, input bit poke);
    int L;
    logic [63:0] w, expw;
    L = (len_in == 0) ? 1 : (len_in > 9 ? 9 : len_in);
    w = {hi, lo};
    polls_left = npoll;
    if (wip) for (int p = 0; p <= npoll; p++) begin
      exp_q.push_back(5); exp_q.push_back(0); exp_q.push_back(-1);
    end
    if (we) begin exp_q.push_back(6); exp_q.push_back(-1); end
    exp_q.push_back(int'(op));
    for (int j = 0; j < L - 1; j++) exp_q.push_back(int'(bsel(w, j)));
    if (!lng) exp_q.push_back(-1);
    @(negedge clk);
    start = 1'b1; opcode = op; total_len = 4'(len_in); wdata_lo = lo; wdata_hi = hi;
    wren_first = we; wait_idle = wip; io2_level = l2; io3_level = l3; long_mode = lng;
    @(negedge clk);
    start = 1'b0;
    while (csn) @(negedge clk);
    chk(io2 == l2 && io3 == l3, "R6 spare IO levels", {62'd0, io2, io3}, {62'd0, l2, l3});
    if (poke) begin
      repeat (20) @(negedge clk);
      start = 1'b1; opcode = 8'hEE; total_len = 4'd3; long_mode = 1'b0;
      @(negedge clk);
      start = 1'b0;
    end
    wait_ready();
    expw = w;
    for (int j = 0; j < L - 1; j++) expw[j*8 +: 8] = resp_base + 8'(j + 1);
    chk({rdata_hi, rdata_lo} == expw, "R3 response written back", {rdata_hi, rdata_lo}, expw);
    fpos = L;
  endtask

  task automatic chunk(input int n_in, input logic [31:0] lo, input logic [31:0] hi, input bit fin);
    int n;
    logic [63:0] w, expw;
    n = (n_in == 0) ? 1 : (n_in > 8 ? 8 : n_in);
    w = {hi, lo};
    for (int j = 0; j < n; j++) exp_q.push_back(int'(bsel(w, j)));
    if (fin) exp_q.push_back(-1);
    @(negedge clk);
    cont = 1'b1; cont_len = 4'(n_in); cont_final = fin; wdata_lo = lo; wdata_hi = hi;
    @(negedge clk);
    cont = 1'b0;
    wait_ready();
    expw = w;
    for (int j = 0; j < n; j++) expw[j*8 +: 8] = resp_base + 8'(fpos + j);
    fpos += n;
    chk({rdata_hi, rdata_lo} == expw, "R7 chunk response", {rdata_hi, rdata_lo}, expw);
    chk(ongoing == !fin, "R7 ongoing flag", 64'(ongoing), 64'(!fin));
    chk(csn == fin, "R7 chip select state", 64'(csn), 64'(fin));
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    mon_en = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(csn && !sck && !ready && !busy && !ongoing, "R11 reset controls",
        {59'd0, csn, sck, ready, busy, ongoing}, 64'h10);
    chk(dev_status == 8'h00 && {rdata_hi, rdata_lo} == 64'd0, "R11 reset data",
        {dev_status, rdata_hi[23:0], rdata_lo}, 64'd0);

    // R1 R3 plain instruction, five bytes
    resp_base = 8'h20;
    issue(8'h9F, 5, 32'h44332211, 32'h88776655, 0, 0, 0, 1, 0, 0, 0);
    // R1 opcode only: nothing overwritten
    resp_base = 8'h30;
    issue(8'h66, 1, 32'hCAFEF00D, 32'h12345678, 0, 0, 0, 0, 1, 0, 0);
    // R1 R3 full nine-byte frame
    resp_base = 8'h50;
    issue(8'h4B, 9, 32'hA1B2C3D4, 32'h0F1E2D3C, 0, 0, 0, 1, 1, 0, 0);
    // R2 length clamping
    resp_base = 8'h60;
    issue(8'hAB, 0, 32'h01020304, 32'h05060708, 0, 0, 0, 0, 0, 0, 0);
    resp_base = 8'h70;
    issue(8'h5A, 13, 32'h99AABBCC, 32'hDDEEFF00, 0, 0, 0, 1, 0, 0, 0);
    // R4 write enable frame first; R9 start poked while busy
    resp_base = 8'h80;
    issue(8'hD8, 4, 32'h00C0FFEE, 32'h0, 1, 0, 0, 0, 1, 0, 1);
    // R5 busy-wait with two busy replies then write enable
    resp_base = 8'h90;
    issue(8'h02, 3, 32'h00005577, 32'h0, 1, 1, 2, 1, 1, 0, 0);
    chk(dev_status == 8'h02, "R5 last status byte", 64'(dev_status), 64'h02);
    // R9 cont with no open frame is ignored
    @(negedge clk);
    cont = 1'b1; cont_len = 4'd2; cont_final = 1'b1;
    @(negedge clk);
    cont = 1'b0;
    begin
      bit moved = 1'b0;
      for (int k = 0; k < 60; k++) begin
        @(negedge clk);
        if (!csn || busy || ready) moved = 1'b1;
      end
      chk(!moved, "R9 stray cont ignored", 64'(moved), 64'd0);
    end
    // R7 chained frame with chunk clamping (R2)
    resp_base = 8'h40;
    issue(8'h7A, 2, 32'h000000E1, 32'h0, 0, 0, 0, 0, 1, 1, 0);
    chk(ongoing && !busy && !csn, "R7 frame held open",
        {61'd0, ongoing, busy, csn}, 64'h4);
    chunk(3, 32'h00C3B2A1, 32'h0, 0);
    chunk(0, 32'h0000005D, 32'h0, 0);
    chunk(10, 32'h13243546, 32'h5768798A, 1);

    repeat (10) @(negedge clk);
    chk(exp_q.size() == 0, "R1 all expected bytes seen", 64'(exp_q.size()), 64'd0);
    chk(min_gap >= GAP, "R4 deselect gap", 64'(min_gap), 64'(GAP));
    chk(sck_bad == 0, "R10 clock idle low", 64'(sck_bad), 64'd0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog R8 no completion actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule